// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and a byte-wide, block-erasable flash store. The host issues bus write cycles. Each cycle is captured when the active-low write strobe returns high, and is decoded as a command. Byte write, block erase and lock-bit changes each take two write cycles: a setup cycle, then a cycle that carries the data or the confirm code. Only after both does an internal sequencer start the operation. It runs the operation for a parameterised number of clock cycles and then commits the result to a small behavioural cell array.

The controller keeps a read mode that decides what a read returns: array bytes, the status byte, or identifier bytes. It drives an active-high ready output. A running erase may be paused so the host can read or byte-write other blocks. A running byte write may be paused for reads only. Reads use a simple request/response stream. A request is accepted in every cycle, and the result appears with a valid flag exactly one cycle later. There is no back-pressure: the host must take the result in that cycle. The cell array keeps its contents through reset, which models non-volatile storage.

Top module: `flash_ctrl_top`

## Requirements
- R1: While reset is held and after it is released, ready is high, no read result is flagged valid, and the read mode is array.
- R2: A bus write takes effect only once the write strobe returns high. The address and data used are those present in the cycle the strobe is first seen high, not earlier values.
- R3: No byte write, erase or lock change starts without its setup cycle. A lone confirm code (0xD0) with no suspended operation does nothing.
- R4: Ready is low while an operation runs, including a byte write nested inside a suspended erase. It is high when idle, when suspended, and during reset.
- R5: Reset clears every status error bit, so the status read after reset is 0x80.
- R6: 0xB0 during an erase suspends it and sets status 0xC0. During the suspension, reads and byte writes to other blocks work. A byte write to the suspended block is refused with write-error. 0xD0 resumes the erase.
- R7: 0xB0 during a byte write suspends it and sets status bit 2, giving 0x84. During that suspension, setup codes for erase, write or lock are ignored and reads still work. 0xD0 resumes the write.
- R8: With the program-voltage-valid input low, no cell or lock bit changes. The attempt sets status bit 3 together with the operation's error bit: bit 4 for a write, bit 5 for an erase.
- R9: Command codes are 0xFF read array, 0x70 read status, 0x90 read identifier, 0x40 or 0x10 byte-write setup, 0x20 erase setup, 0x60 lock setup, 0xB0 suspend and 0xD0 confirm/resume. In identifier mode, offset 0 returns the maker code and offset 1 returns the device code.
- R10: Status bits are: 7 ready, 6 erase suspended, 5 erase error, 4 write error, 3 voltage error, 2 write suspended, 1 lock error. Error bits stay set until command 0x50 clears them.
- R11: An erase confirm other than 0xD0 sets bits 5 and 4, starts nothing, and leaves the controller in status read mode.
- R12: An erase fills every byte of the block picked by the upper address bits with 0xFF. A byte write stores the bitwise AND of the old and new data.
- R13: Lock setup followed by 0x01 locks the addressed block, and lock setup followed by 0xD0 unlocks all blocks. A write or erase to a locked block sets bit 1 with bit 4 or bit 5 and changes nothing. Identifier offset 2 returns the block's lock bit in bit 0.
- R14: Cell contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down; blocks all writes |
| vpp_ok | input | 1 | Program voltage valid |
| we_n | input | 1 | Active-low bus write strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data / command code |
| rd_req | input | 1 | Read request, one per cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid, one cycle after request |
| rd_data | output | 8 | Read result |
| ready | output | 1 | High when no operation is running |

## Verification
The bench targets the corner cases of suspension. If a suspended erase were not actually paused, the block would read as erased before the resume. If a nested write were allowed into the suspended block, that block would be corrupted, and if setup codes were accepted during a suspended write, a new operation would start beside it. It also targets the cases where error bits are cleared or flagged. A controller that cleared errors on a mode change would lose the bad-confirm flags. One that ignored the voltage input would change cells and set no bit 3. One that ignored locks would overwrite a protected block. The strobe test changes the data while the strobe is low. A design that latched on the falling edge would decode the early code instead of the final one.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2
  } rmode_e;

  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_PROG  = 2'd1,
    PD_ERASE = 2'd2,
    PD_LOCK  = 2'd3
  } pend_e;

  localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] OP_READ_ID      = 8'h90;
  localparam logic [7:0] OP_PROG_SETUP   = 8'h40;
  localparam logic [7:0] OP_PROG_ALT     = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] OP_LOCK_SETUP   = 8'h60;
  localparam logic [7:0] OP_LOCK_SET     = 8'h01;
  localparam logic [7:0] OP_CONFIRM      = 8'hD0;
  localparam logic [7:0] OP_SUSPEND      = 8'hB0;

  localparam int SB_READY = 7;
  localparam int SB_ESUS  = 6;
  localparam int SB_EERR  = 5;
  localparam int SB_WERR  = 4;
  localparam int SB_VERR  = 3;
  localparam int SB_WSUS  = 2;
  localparam int SB_LERR  = 1;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);

  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      cmd_stb  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      we_q    <= we_n;
      cmd_stb <= !we_q && we_n;
      if (!we_q && we_n) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end

  // R2: a command strobe only follows a low-then-high strobe sequence
  a_r2_rising_edge: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(we_n) && !$past(we_n, 2)));

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int BLK_W = 2,
  parameter int OFS_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vpp_ok,
  input  logic                   prog_go,
  input  logic [BLK_W+OFS_W-1:0] prog_addr,
  input  logic [7:0]             prog_data,
  input  logic                   erase_go,
  input  logic [BLK_W-1:0]       erase_blk,
  input  logic                   lock_set_go,
  input  logic                   lock_clr_go,
  input  logic [BLK_W-1:0]       lock_blk,
  input  logic [BLK_W+OFS_W-1:0] rd_addr,
  output logic [7:0]             rd_byte,
  output logic [(1<<BLK_W)-1:0]  lock_vec
);

  localparam int ADDR_W = BLK_W + OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NBLK   = 1 << BLK_W;

  logic [7:0]      mem [DEPTH];
  logic [NBLK-1:0] lock_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (erase_go && (BLK_W'(i >> OFS_W) == erase_blk)) begin
        mem[i] <= 8'hFF;
      end else if (prog_go && (ADDR_W'(i) == prog_addr)) begin
        mem[i] <= mem[i] & prog_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NBLK; j++) begin
      if (lock_clr_go) begin
        lock_q[j] <= 1'b0;
      end else if (lock_set_go && (BLK_W'(j) == lock_blk)) begin
        lock_q[j] <= 1'b1;
      end
    end
  end

  assign rd_byte  = mem[rd_addr];
  assign lock_vec = lock_q;

  // R8: nothing is committed without a valid program voltage
  a_r8_commit_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go || lock_set_go || lock_clr_go) |-> vpp_ok);

  // R13: locked blocks never receive a write or erase commit
  a_r13_prog_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> !lock_q[prog_addr[ADDR_W-1:OFS_W]]);
  a_r13_erase_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> !lock_q[erase_blk]);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_ctrl_pkg::*;
#(
  parameter int BLK_W     = 2,
  parameter int OFS_W     = 3,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  parameter int LOCK_CYC  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vpp_ok,
  input  logic                   cmd_stb,
  input  logic [BLK_W+OFS_W-1:0] cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic [(1<<BLK_W)-1:0]  lock_vec,
  output rmode_e                 rmode,
  output logic [7:0]             status,
  output logic                   busy,
  output logic                   prog_go,
  output logic [BLK_W+OFS_W-1:0] prog_addr,
  output logic [7:0]             prog_data,
  output logic                   erase_go,
  output logic [BLK_W-1:0]       erase_blk,
  output logic                   lock_set_go,
  output logic                   lock_clr_go,
  output logic [BLK_W-1:0]       lock_blk
);

  localparam int ADDR_W = BLK_W + OFS_W;
  localparam int MAXPE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC   = (MAXPE > LOCK_CYC) ? MAXPE : LOCK_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  localparam logic [7:0] M_EERR = 8'(1 << SB_EERR);
  localparam logic [7:0] M_WERR = 8'(1 << SB_WERR);
  localparam logic [7:0] M_VERR = 8'(1 << SB_VERR);
  localparam logic [7:0] M_LERR = 8'(1 << SB_LERR);

  pend_e             pend_q, pend_d;
  rmode_e            rmode_q, rmode_d;
  logic              e_act_q, e_act_d, e_sus_q, e_sus_d;
  logic [BLK_W-1:0]  e_blk_q, e_blk_d;
  logic [CNT_W-1:0]  e_cnt_q, e_cnt_d;
  logic              p_act_q, p_act_d, p_sus_q, p_sus_d;
  logic [ADDR_W-1:0] p_addr_q, p_addr_d;
  logic [7:0]        p_data_q, p_data_d;
  logic [CNT_W-1:0]  p_cnt_q, p_cnt_d;
  logic              l_act_q, l_act_d, l_set_q, l_set_d;
  logic [BLK_W-1:0]  l_blk_q, l_blk_d;
  logic [CNT_W-1:0]  l_cnt_q, l_cnt_d;
  logic [7:0]        err_q, err_d, err_set;
  logic              err_clr;
  logic              e_run, p_run;
  logic [BLK_W-1:0]  cblk;

  assign e_run = e_act_q && !e_sus_q;
  assign p_run = p_act_q && !p_sus_q;
  assign busy  = e_run || p_run || l_act_q;
  assign cblk  = cmd_addr[ADDR_W-1:OFS_W];

  always_comb begin
    pend_d = pend_q;   rmode_d = rmode_q;
    e_act_d = e_act_q; e_sus_d = e_sus_q; e_blk_d = e_blk_q; e_cnt_d = e_cnt_q;
    p_act_d = p_act_q; p_sus_d = p_sus_q; p_addr_d = p_addr_q;
    p_data_d = p_data_q; p_cnt_d = p_cnt_q;
    l_act_d = l_act_q; l_set_d = l_set_q; l_blk_d = l_blk_q; l_cnt_d = l_cnt_q;
    err_set = '0; err_clr = 1'b0;
    prog_go = 1'b0; erase_go = 1'b0; lock_set_go = 1'b0; lock_clr_go = 1'b0;

    // operation timers and commit
    if (p_run) begin
      if (p_cnt_q == '0) begin
        p_act_d = 1'b0;
        if (vpp_ok) prog_go = 1'b1;
        else        err_set = err_set | M_WERR | M_VERR;
      end else begin
        p_cnt_d = p_cnt_q - 1'b1;
      end
    end
    if (e_run) begin
      if (e_cnt_q == '0) begin
        e_act_d = 1'b0;
        if (vpp_ok) erase_go = 1'b1;
        else        err_set = err_set | M_EERR | M_VERR;
      end else begin
        e_cnt_d = e_cnt_q - 1'b1;
      end
    end
    if (l_act_q) begin
      if (l_cnt_q == '0) begin
        l_act_d = 1'b0;
        if (!vpp_ok)      err_set = err_set | M_VERR | (l_set_q ? M_WERR : M_EERR);
        else if (l_set_q) lock_set_go = 1'b1;
        else              lock_clr_go = 1'b1;
      end else begin
        l_cnt_d = l_cnt_q - 1'b1;
      end
    end

    // command decode
    if (cmd_stb) begin
      if (pend_q != PD_NONE) begin
        pend_d  = PD_NONE;
        rmode_d = RM_STATUS;
        case (pend_q)
          PD_PROG: begin
            if (lock_vec[cblk])                err_set = err_set | M_WERR | M_LERR;
            else if (!vpp_ok)                  err_set = err_set | M_WERR | M_VERR;
            else if (e_act_q && cblk == e_blk_q) err_set = err_set | M_WERR;
            else begin
              p_act_d = 1'b1; p_sus_d = 1'b0;
              p_addr_d = cmd_addr; p_data_d = cmd_data;
              p_cnt_d = CNT_W'(PROG_CYC - 1);
            end
          end
          PD_ERASE: begin
            if (cmd_data != OP_CONFIRM)  err_set = err_set | M_EERR | M_WERR;
            else if (lock_vec[cblk])     err_set = err_set | M_EERR | M_LERR;
            else if (!vpp_ok)            err_set = err_set | M_EERR | M_VERR;
            else begin
              e_act_d = 1'b1; e_sus_d = 1'b0; e_blk_d = cblk;
              e_cnt_d = CNT_W'(ERASE_CYC - 1);
            end
          end
          PD_LOCK: begin
            if (cmd_data == OP_LOCK_SET || cmd_data == OP_CONFIRM) begin
              if (!vpp_ok) begin
                err_set = err_set | M_VERR |
                          ((cmd_data == OP_LOCK_SET) ? M_WERR : M_EERR);
              end else begin
                l_act_d = 1'b1; l_set_d = (cmd_data == OP_LOCK_SET);
                l_blk_d = cblk; l_cnt_d = CNT_W'(LOCK_CYC - 1);
              end
            end else begin
              err_set = err_set | M_EERR | M_WERR;
            end
          end
          default: ;
        endcase
      end else if (busy) begin
        if (cmd_data == OP_SUSPEND) begin
          if (p_run && !e_act_q && p_cnt_q != '0) begin
            p_sus_d = 1'b1; rmode_d = RM_STATUS;
          end else if (e_run && e_cnt_q != '0) begin
            e_sus_d = 1'b1; rmode_d = RM_STATUS;
          end
        end
      end else begin
        case (cmd_data)
          OP_READ_ARRAY:   rmode_d = RM_ARRAY;
          OP_READ_STATUS:  rmode_d = RM_STATUS;
          OP_READ_ID:      rmode_d = RM_IDENT;
          OP_CLEAR_STATUS: err_clr = 1'b1;
          OP_PROG_SETUP, OP_PROG_ALT: begin
            if (!p_sus_q) begin pend_d = PD_PROG; rmode_d = RM_STATUS; end
          end
          OP_ERASE_SETUP: begin
            if (!p_sus_q && !e_sus_q) begin pend_d = PD_ERASE; rmode_d = RM_STATUS; end
          end
          OP_LOCK_SETUP: begin
            if (!p_sus_q && !e_sus_q) begin pend_d = PD_LOCK; rmode_d = RM_STATUS; end
          end
          OP_CONFIRM: begin
            if (p_sus_q)      begin p_sus_d = 1'b0; rmode_d = RM_STATUS; end
            else if (e_sus_q) begin e_sus_d = 1'b0; rmode_d = RM_STATUS; end
          end
          default: ;
        endcase
      end
    end

    err_d = (err_clr ? 8'h00 : err_q) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_NONE; rmode_q <= RM_ARRAY;
      e_act_q <= 1'b0; e_sus_q <= 1'b0; e_blk_q <= '0; e_cnt_q <= '0;
      p_act_q <= 1'b0; p_sus_q <= 1'b0; p_addr_q <= '0; p_data_q <= '0; p_cnt_q <= '0;
      l_act_q <= 1'b0; l_set_q <= 1'b0; l_blk_q <= '0; l_cnt_q <= '0;
      err_q <= '0;
    end else begin
      pend_q <= pend_d; rmode_q <= rmode_d;
      e_act_q <= e_act_d; e_sus_q <= e_sus_d; e_blk_q <= e_blk_d; e_cnt_q <= e_cnt_d;
      p_act_q <= p_act_d; p_sus_q <= p_sus_d; p_addr_q <= p_addr_d;
      p_data_q <= p_data_d; p_cnt_q <= p_cnt_d;
      l_act_q <= l_act_d; l_set_q <= l_set_d; l_blk_q <= l_blk_d; l_cnt_q <= l_cnt_d;
      err_q <= err_d;
    end
  end

  assign rmode     = rmode_q;
  assign status    = {~busy, e_sus_q, err_q[SB_EERR], err_q[SB_WERR],
                      err_q[SB_VERR], p_sus_q, err_q[SB_LERR], 1'b0};
  assign prog_addr = p_addr_q;
  assign prog_data = p_data_q;
  assign erase_blk = e_blk_q;
  assign lock_blk  = l_blk_q;

  // R3: operations start only right after their setup cycle
  a_r3_prog_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_act_q) |-> ($past(pend_q) == PD_PROG));
  a_r3_erase_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_act_q) |-> ($past(pend_q) == PD_ERASE));

  // R4: ready drops as soon as an erase starts
  a_r4_busy_on_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_act_q) |-> busy);

  // R6: a write nested in a suspended erase targets another block
  a_r6_nested_other_blk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act_q && e_sus_q) |-> (p_addr_q[ADDR_W-1:OFS_W] != e_blk_q));

  // R7: a suspended write admits no new operation or setup
  a_r7_wsus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    p_sus_q |-> (pend_q == PD_NONE && !l_act_q && !e_act_q));

  // R10: error bits fall only after a clear-status command
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_q) & ~err_q) != 8'h00) |->
      ($past(cmd_stb) && $past(cmd_data) == OP_CLEAR_STATUS));

  // R11: a bad erase confirm flags both error bits and selects status mode
  a_r11_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && pend_q == PD_ERASE && cmd_data != OP_CONFIRM) |=>
      (err_q[SB_EERR] && err_q[SB_WERR] && rmode_q == RM_STATUS));

endmodule

// File: rtl/flash_ctrl_top.sv
module flash_ctrl_top
  import flash_ctrl_pkg::*;
#(
  parameter int         BLK_W     = 2,
  parameter int         OFS_W     = 3,
  parameter int         PROG_CYC  = 6,
  parameter int         ERASE_CYC = 12,
  parameter int         LOCK_CYC  = 3,
  parameter logic [7:0] MFR_ID    = 8'h3E,
  parameter logic [7:0] DEV_ID    = 8'hA7,
  localparam int        ADDR_W    = BLK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              ready
);

  localparam int NBLK = 1 << BLK_W;

  logic              cmd_stb;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  rmode_e            rmode;
  logic [7:0]        status;
  logic              busy;
  logic              prog_go, erase_go, lock_set_go, lock_clr_go;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]        prog_data;
  logic [BLK_W-1:0]  erase_blk, lock_blk;
  logic [NBLK-1:0]   lock_vec;
  logic [7:0]        cell_byte, id_byte, rd_mux;

  flash_bus_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  flash_cmd_fsm #(
    .BLK_W(BLK_W), .OFS_W(OFS_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .lock_vec(lock_vec), .rmode(rmode), .status(status), .busy(busy),
    .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_go(erase_go), .erase_blk(erase_blk),
    .lock_set_go(lock_set_go), .lock_clr_go(lock_clr_go), .lock_blk(lock_blk)
  );

  flash_cell_array #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok),
    .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_go(erase_go), .erase_blk(erase_blk),
    .lock_set_go(lock_set_go), .lock_clr_go(lock_clr_go), .lock_blk(lock_blk),
    .rd_addr(rd_addr), .rd_byte(cell_byte), .lock_vec(lock_vec)
  );

  always_comb begin
    case (rd_addr[OFS_W-1:0])
      OFS_W'(0): id_byte = MFR_ID;
      OFS_W'(1): id_byte = DEV_ID;
      OFS_W'(2): id_byte = {7'b0, lock_vec[rd_addr[ADDR_W-1:OFS_W]]};
      default:   id_byte = 8'h00;
    endcase
    case (rmode)
      RM_ARRAY: rd_mux = cell_byte;
      RM_IDENT: rd_mux = id_byte;
      default:  rd_mux = status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  assign ready = ~busy;

  // R1: every read request yields a valid result exactly one cycle later
  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

endmodule

// File: tb/flash_ctrl_top_bench.sv
module flash_ctrl_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 25;

  // {read, addr, data, expected}: read=0 is a bus write, read=1 checks a read
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h60, 8'h00}, {1'b0, 8'h00, 8'hD0, 8'h00},
    {1'b0, 8'h08, 8'h20, 8'h00}, {1'b0, 8'h08, 8'hD0, 8'h00},
    {1'b0, 8'h10, 8'h20, 8'h00}, {1'b0, 8'h10, 8'hD0, 8'h00},
    {1'b0, 8'h00, 8'hFF, 8'h00}, {1'b1, 8'h08, 8'h00, 8'hFF},
    {1'b1, 8'h0F, 8'h00, 8'hFF}, {1'b1, 8'h17, 8'h00, 8'hFF},
    {1'b0, 8'h00, 8'h40, 8'h00}, {1'b0, 8'h09, 8'h3C, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h80}, {1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'h09, 8'h00, 8'h3C}, {1'b0, 8'h00, 8'h10, 8'h00},
    {1'b0, 8'h09, 8'hF0, 8'h00}, {1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'h09, 8'h00, 8'h30}, {1'b0, 8'h00, 8'h90, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h3E}, {1'b1, 8'h01, 8'h00, 8'hA7},
    {1'b1, 8'h0A, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h70, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vpp_ok = 1'b1;
  logic       we_n = 1'b1;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_req = 1'b0;
  logic [4:0] rd_addr = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       ready;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] got;

  flash_ctrl_top u_flash_ctrl_top (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .we_n(we_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we_n = 1'b0; wr_addr = a; wr_data = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    @(negedge clk); rd_req = 1'b0; d = rd_data;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 500 && !ready; k++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ready in reset", {7'b0, ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {7'b0, ready}, 8'h01);
    check("R1 no read valid", {7'b0, rd_valid}, 8'h00);
    bus_write(5'h00, 8'h70);
    bus_read(5'h00, got); check("R5 status after reset", got, 8'h80);

    // vector table: R9 codes, R12 erase fill and AND write, R13 id lock offset
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        bus_read(VEC[v][20:16], got);
        check($sformatf("R9 R12 row %0d", v), got, VEC[v][7:0]);
      end else begin
        bus_write(VEC[v][20:16], VEC[v][15:8]);
        wait_ready();
      end
    end

    // R11 bad confirm
    bus_write(5'h08, 8'h20); bus_write(5'h08, 8'h33);
    check("R11 no start", {7'b0, ready}, 8'h01);
    bus_read(5'h00, got); check("R11 bad confirm status", got, 8'hB0);
    bus_write(5'h00, 8'hFF); bus_write(5'h00, 8'h70);
    bus_read(5'h00, got); check("R10 errors sticky", got, 8'hB0);

    // reset: R4 ready, R1 array mode, R14 retained, R5 errors cleared
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 ready in power-down", {7'b0, ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(5'h09, got); check("R14 R1 array kept and read", got, 8'h30);
    bus_write(5'h00, 8'h70);
    bus_read(5'h00, got); check("R5 status cleared", got, 8'h80);

    // R8 program voltage
    vpp_ok = 1'b0;
    bus_write(5'h00, 8'h40); bus_write(5'h09, 8'h00);
    check("R8 write not started", {7'b0, ready}, 8'h01);
    bus_read(5'h00, got); check("R8 write vpp status", got, 8'h98);
    bus_write(5'h00, 8'h50);
    bus_read(5'h00, got); check("R10 clear status", got, 8'h80);
    bus_write(5'h08, 8'h20); bus_write(5'h08, 8'hD0);
    bus_read(5'h00, got); check("R8 erase vpp status", got, 8'hA8);
    bus_write(5'h00, 8'h50);
    vpp_ok = 1'b1;
    bus_write(5'h00, 8'hFF);
    bus_read(5'h09, got); check("R8 cell unchanged", got, 8'h30);

    // R13 locks
    bus_write(5'h18, 8'h60); bus_write(5'h18, 8'h01); wait_ready();
    bus_write(5'h00, 8'h90);
    bus_read(5'h1A, got); check("R13 lock bit set", got, 8'h01);
    bus_write(5'h00, 8'h40); bus_write(5'h19, 8'h00);
    bus_read(5'h00, got); check("R13 locked write", got, 8'h92);
    bus_write(5'h00, 8'h50);
    bus_write(5'h18, 8'h20); bus_write(5'h18, 8'hD0);
    bus_read(5'h00, got); check("R13 locked erase", got, 8'hA2);
    bus_write(5'h00, 8'h50);
    bus_write(5'h00, 8'h60); bus_write(5'h00, 8'hD0); wait_ready();
    bus_write(5'h00, 8'h90);
    bus_read(5'h1A, got); check("R13 locks cleared", got, 8'h00);

    // R6 erase suspend
    bus_write(5'h08, 8'h20); bus_write(5'h08, 8'hD0);
    check("R4 busy during erase", {7'b0, ready}, 8'h00);
    bus_write(5'h00, 8'hB0);
    check("R6 ready when suspended", {7'b0, ready}, 8'h01);
    bus_read(5'h00, got); check("R6 erase suspended status", got, 8'hC0);
    bus_write(5'h00, 8'hFF);
    bus_read(5'h09, got); check("R6 erase paused", got, 8'h30);
    bus_write(5'h00, 8'h40); bus_write(5'h10, 8'h5A);
    check("R4 busy nested write", {7'b0, ready}, 8'h00);
    bus_read(5'h00, got); check("R4 nested busy status", got, 8'h40);
    wait_ready();
    bus_read(5'h00, got); check("R6 back to suspended", got, 8'hC0);
    bus_write(5'h00, 8'h40); bus_write(5'h0A, 8'h00);
    bus_read(5'h00, got); check("R6 same block refused", got, 8'hD0);
    bus_write(5'h00, 8'h50);
    bus_write(5'h00, 8'hD0);
    check("R6 resumed busy", {7'b0, ready}, 8'h00);
    wait_ready();
    bus_read(5'h00, got); check("R6 erase done status", got, 8'h80);
    bus_write(5'h00, 8'hFF);
    bus_read(5'h09, got); check("R12 erase after resume", got, 8'hFF);
    bus_read(5'h10, got); check("R6 nested write kept", got, 8'h5A);

    // R7 write suspend
    bus_write(5'h00, 8'h40); bus_write(5'h11, 8'h0F);
    bus_write(5'h00, 8'hB0);
    check("R7 ready when suspended", {7'b0, ready}, 8'h01);
    bus_read(5'h00, got); check("R7 write suspended status", got, 8'h84);
    bus_write(5'h08, 8'h20);
    check("R7 setup ignored ready", {7'b0, ready}, 8'h01);
    bus_read(5'h00, got); check("R7 setup ignored status", got, 8'h84);
    bus_write(5'h00, 8'hFF);
    bus_read(5'h10, got); check("R7 read during suspend", got, 8'h5A);
    bus_write(5'h00, 8'hD0); wait_ready();
    bus_write(5'h00, 8'h70);
    bus_read(5'h00, got); check("R7 resumed done", got, 8'h80);
    bus_write(5'h00, 8'hFF);
    bus_read(5'h11, got); check("R12 AND into erased byte", got, 8'h0F);

    // R3 lone confirm
    bus_write(5'h10, 8'hD0);
    check("R3 lone confirm idle", {7'b0, ready}, 8'h00 | {7'b0, 1'b1});
    bus_read(5'h10, got); check("R3 lone confirm no erase", got, 8'h5A);

    // R2 capture on strobe rising edge
    @(negedge clk); we_n = 1'b0; wr_addr = 5'h00; wr_data = 8'h90;
    repeat (3) @(negedge clk);
    wr_data = 8'h70;
    bus_read(5'h10, got); check("R2 no action while strobe low", got, 8'h5A);
    @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(5'h00, got); check("R2 late data latched", got, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule